// File: doc/BRIEF.md
# Two-Level Thermal Degrade Controller

This block turns a stream of board temperature samples into the policy that a passive cell-balancing scheduler must obey. It holds one of three operating levels. At the normal level the scheduler may run as many channels as configured, up to two. At the degraded level only one channel may run and every channel's cool-down must be doubled. At the shutdown level all balancing must stop. A rise past a threshold takes effect on the next sample. Falling back needs the temperature to drop below that threshold by a programmable margin, so noise near a threshold cannot make the outputs chatter.

While the controller stays at the normal level, a sample that lies just under the first threshold counts as a warning. On a warning, the controller asks the scheduler to skip the zone that is active at that moment. The skip lasts for a fixed number of zone rotations. Temperature samples arrive with a valid strobe, and the level changes only when a sample arrives. If the sensor goes silent for a programmable number of cycles, the controller shuts down, and it starts in shutdown after reset.

Top module: `thermal_degrade_ctrl`

## Requirements
- R1: After reset the block is at the shutdown level: `bal_global_off`=1, `conc_limit`=0, `off_time_x2`=1, `zone_skip_req`=0. At the shutdown level `conc_limit` is always 0 and `off_time_x2` is always 1.
- R2: A valid sample strictly greater than `thr_hi` puts the block at the shutdown level on the next cycle, whatever the current level.
- R3: At the normal level, a valid sample greater than `thr_lo` and not greater than `thr_hi` moves the block to the degraded level: `conc_limit`=1, `off_time_x2`=1, `bal_global_off`=0.
- R4: At the normal level `conc_limit` equals `cfg_conc` limited to a maximum of 2, and `off_time_x2`=0 and `bal_global_off`=0.
- R5: The degraded level returns to normal only on a valid sample strictly below `thr_lo - hyst_margin`. That recovery point is taken as 0 when the margin is not smaller than the threshold, so recovery is then impossible.
- R6: From the shutdown level, a valid sample strictly below `thr_hi - hyst_margin` leaves shutdown. The block goes straight to normal if the sample is also below the first recovery point, and to degraded otherwise. Any other valid sample keeps the block at shutdown.
- R7: Without a valid sample the level does not change, except through the timeout of R8.
- R8: After TIMEOUT_CYC consecutive cycles without a valid strobe, the block is at the shutdown level. A valid strobe in the cycle that would complete the count prevents the timeout and restarts the count.
- R9: A warning arms a skip. A warning is a valid sample taken at the normal level that keeps the level normal and lies between the first recovery point and `thr_lo`, both ends included, while no skip is active. One cycle later `zone_skip_req`=1 and `zone_skip_id` holds the `active_zone` value of the sample cycle.
- R10: An armed skip ends after SKIP_ROT pulses of `rot_tick`. A pulse in the arming cycle is not counted. Warnings received while a skip is active neither extend it nor change `zone_skip_id`.
- R11: Leaving the normal level cancels any active skip on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_vld | input | 1 | Temperature sample strobe |
| temp_code | input | TEMP_W | Temperature sample, unsigned code |
| thr_lo | input | TEMP_W | First (degrade) threshold |
| thr_hi | input | TEMP_W | Second (shutdown) threshold |
| hyst_margin | input | TEMP_W | Recovery margin below each threshold |
| cfg_conc | input | CONC_W | Configured channel concurrency |
| rot_tick | input | 1 | One pulse per zone rotation step of the scheduler |
| active_zone | input | ZONE_W | Zone the scheduler is currently serving |
| conc_limit | output | CONC_W | Effective concurrency limit |
| off_time_x2 | output | 1 | Double the per-channel cool-down |
| bal_global_off | output | 1 | Global balancing disable request |
| zone_skip_req | output | 1 | Skip the zone named by `zone_skip_id` |
| zone_skip_id | output | ZONE_W | Zone to skip |

## Verification
Two functions can fall in the same cycle: the expiry of the sample timeout, and the arrival of a valid sample. The bench leaves the strobe low for exactly TIMEOUT_CYC-1 cycles and then delivers a cool sample in the cycle that would complete the count, so R8 requires that the sample wins. The second pair is a `rot_tick` pulse in the same cycle as a warning that arms a skip. The per-cycle reference model must show the skip still holding its full rotation count afterwards.

// File: rtl/thermal_degrade_pkg.sv
package thermal_degrade_pkg;

    typedef enum logic [1:0] {
        LVL_NORMAL   = 2'd0,
        LVL_DEGRADED = 2'd1,
        LVL_SHUTDOWN = 2'd2
    } lvl_e;

    localparam int unsigned MAX_CONC = 2;

endpackage

// File: rtl/tdc_level_eval.sv
module tdc_level_eval
    import thermal_degrade_pkg::*;
#(
    parameter int unsigned TEMP_W = 10
) (
    input  lvl_e              lvl_cur,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] thr_lo,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] hyst_margin,
    output lvl_e              lvl_new,
    output logic              warn_band
);

    logic [TEMP_W-1:0] rec_lo;
    logic [TEMP_W-1:0] rec_hi;
    logic              above_hi;
    logic              above_lo;
    logic              below_rec_lo;
    logic              below_rec_hi;

    always_comb begin
        // Recovery points saturate at zero: no code lies below zero.
        rec_lo       = (thr_lo > hyst_margin) ? (thr_lo - hyst_margin) : '0;
        rec_hi       = (thr_hi > hyst_margin) ? (thr_hi - hyst_margin) : '0;
        above_hi     = temp_code > thr_hi;
        above_lo     = temp_code > thr_lo;
        below_rec_lo = temp_code < rec_lo;
        below_rec_hi = temp_code < rec_hi;

        lvl_new = lvl_cur;
        if (above_hi) begin
            lvl_new = LVL_SHUTDOWN;
        end else begin
            unique case (lvl_cur)
                LVL_NORMAL: begin
                    if (above_lo) lvl_new = LVL_DEGRADED;
                end
                LVL_DEGRADED: begin
                    if (below_rec_lo) lvl_new = LVL_NORMAL;
                end
                default: begin
                    if (below_rec_hi) begin
                        lvl_new = below_rec_lo ? LVL_NORMAL : LVL_DEGRADED;
                    end else begin
                        lvl_new = LVL_SHUTDOWN;
                    end
                end
            endcase
        end

        warn_band = !below_rec_lo && !above_lo;
    end

endmodule

// File: rtl/tdc_stale_timer.sv
module tdc_stale_timer #(
    parameter int unsigned TIMEOUT_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_vld,
    output logic expire
);

    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] idle;
    } tmr_t;

    tmr_t tmr_d;
    tmr_t tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (sample_vld) begin
            tmr_d.idle = '0;
        end else begin
            // This cycle completes (or has passed) the silent window.
            expire = tmr_q.idle >= CNT_LAST;
            if (tmr_q.idle != CNT_SAT) tmr_d.idle = tmr_q.idle + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/tdc_zone_skip.sv
module tdc_zone_skip #(
    parameter int unsigned ZONE_W   = 1,
    parameter int unsigned SKIP_ROT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cancel,
    input  logic              rot_tick,
    input  logic [ZONE_W-1:0] zone_in,
    output logic              skip_req,
    output logic [ZONE_W-1:0] skip_zone
);

    localparam int unsigned SK_W = $clog2(SKIP_ROT + 1);
    localparam logic [SK_W-1:0] SK_FULL = SK_W'(SKIP_ROT);

    typedef struct packed {
        logic [SK_W-1:0]   left;
        logic [ZONE_W-1:0] zone;
    } skip_t;

    skip_t sk_d;
    skip_t sk_q;

    always_comb begin
        sk_d = sk_q;
        if (cancel) begin
            sk_d.left = '0;
        end else if (arm && sk_q.left == '0) begin
            sk_d.left = SK_FULL;
            sk_d.zone = zone_in;
        end else if (rot_tick && sk_q.left != '0) begin
            sk_d.left = sk_q.left - 1'b1;
        end
        skip_req  = sk_q.left != '0;
        skip_zone = sk_q.zone;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= '0;
        else        sk_q <= sk_d;
    end

endmodule

// File: rtl/thermal_degrade_ctrl.sv
module thermal_degrade_ctrl
    import thermal_degrade_pkg::*;
#(
    parameter int unsigned TEMP_W      = 10,
    parameter int unsigned TIMEOUT_CYC = 40,
    parameter int unsigned NUM_ZONES   = 2,
    parameter int unsigned SKIP_ROT    = 2,
    parameter int unsigned ZONE_W      = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1,
    parameter int unsigned CONC_W      = $clog2(MAX_CONC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_vld,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic [TEMP_W-1:0] thr_lo,
    input  logic [TEMP_W-1:0] thr_hi,
    input  logic [TEMP_W-1:0] hyst_margin,
    input  logic [CONC_W-1:0] cfg_conc,
    input  logic              rot_tick,
    input  logic [ZONE_W-1:0] active_zone,
    output logic [CONC_W-1:0] conc_limit,
    output logic              off_time_x2,
    output logic              bal_global_off,
    output logic              zone_skip_req,
    output logic [ZONE_W-1:0] zone_skip_id
);

    localparam logic [CONC_W-1:0] CONC_CAP = CONC_W'(MAX_CONC);

    typedef struct packed {
        lvl_e lvl;
    } ctl_t;

    ctl_t ctl_d;
    ctl_t ctl_q;

    lvl_e lvl_eval;
    logic warn_band;
    logic stale;
    logic skip_arm;
    logic skip_cancel;

    tdc_level_eval #(.TEMP_W(TEMP_W)) u_eval (
        .lvl_cur     (ctl_q.lvl),
        .temp_code   (temp_code),
        .thr_lo      (thr_lo),
        .thr_hi      (thr_hi),
        .hyst_margin (hyst_margin),
        .lvl_new     (lvl_eval),
        .warn_band   (warn_band)
    );

    tdc_stale_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_stale (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (temp_vld),
        .expire     (stale)
    );

    tdc_zone_skip #(.ZONE_W(ZONE_W), .SKIP_ROT(SKIP_ROT)) u_skip (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (skip_arm),
        .cancel    (skip_cancel),
        .rot_tick  (rot_tick),
        .zone_in   (active_zone),
        .skip_req  (zone_skip_req),
        .skip_zone (zone_skip_id)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (temp_vld)   ctl_d.lvl = lvl_eval;
        else if (stale) ctl_d.lvl = LVL_SHUTDOWN;

        skip_arm    = temp_vld && warn_band &&
                      ctl_q.lvl == LVL_NORMAL && lvl_eval == LVL_NORMAL;
        skip_cancel = ctl_d.lvl != LVL_NORMAL;

        unique case (ctl_q.lvl)
            LVL_NORMAL: begin
                conc_limit     = (cfg_conc > CONC_CAP) ? CONC_CAP : cfg_conc;
                off_time_x2    = 1'b0;
                bal_global_off = 1'b0;
            end
            LVL_DEGRADED: begin
                conc_limit     = CONC_W'(1);
                off_time_x2    = 1'b1;
                bal_global_off = 1'b0;
            end
            default: begin
                conc_limit     = '0;
                off_time_x2    = 1'b1;
                bal_global_off = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.lvl <= LVL_SHUTDOWN;
        else        ctl_q     <= ctl_d;
    end

endmodule

// File: rtl/thermal_degrade_ctrl_chk.sv
module thermal_degrade_ctrl_chk #(
    parameter int unsigned TEMP_W = 10,
    parameter int unsigned CONC_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              temp_vld,
    input logic [TEMP_W-1:0] temp_code,
    input logic [TEMP_W-1:0] thr_lo,
    input logic [TEMP_W-1:0] thr_hi,
    input logic [TEMP_W-1:0] hyst_margin,
    input logic [CONC_W-1:0] conc_limit,
    input logic              off_time_x2,
    input logic              bal_global_off,
    input logic              zone_skip_req
);

    logic [TEMP_W-1:0] rec_lo_c;
    assign rec_lo_c = (thr_lo > hyst_margin) ? (thr_lo - hyst_margin) : '0;

    a_r1_shutdown_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        bal_global_off |-> (conc_limit == '0 && off_time_x2));

    a_r2_crit_shuts: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld && temp_code > thr_hi) |=> bal_global_off);

    a_r3_degrade_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld && temp_code > thr_lo && temp_code <= thr_hi &&
         !off_time_x2 && !bal_global_off)
        |=> (conc_limit == CONC_W'(1) && off_time_x2 && !bal_global_off));

    a_r5_degrade_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_vld && off_time_x2 && !bal_global_off &&
         temp_code >= rec_lo_c && temp_code <= thr_hi)
        |=> (off_time_x2 && !bal_global_off));

    a_r7_no_silent_change: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_vld |=> (bal_global_off || $stable(off_time_x2)));

    a_r11_skip_normal_only: assert property (@(posedge clk) disable iff (!rst_n)
        zone_skip_req |-> (!off_time_x2 && !bal_global_off));

endmodule

bind thermal_degrade_ctrl thermal_degrade_ctrl_chk #(
    .TEMP_W (TEMP_W),
    .CONC_W (CONC_W)
) u_chk (.*);

// File: tb/thermal_degrade_ctrl_test.sv
module thermal_degrade_ctrl_test;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned TEMP_W     = 10;
    localparam int unsigned TMO        = 20;
    localparam int unsigned SKIPN      = 2;
    localparam int unsigned ZONE_W     = 2;
    localparam int unsigned CONC_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              temp_vld = 1'b0;
    logic [TEMP_W-1:0] temp_code = '0;
    logic [TEMP_W-1:0] thr_lo = TEMP_W'(100);
    logic [TEMP_W-1:0] thr_hi = TEMP_W'(150);
    logic [TEMP_W-1:0] hyst_margin = TEMP_W'(10);
    logic [CONC_W-1:0] cfg_conc = CONC_W'(2);
    logic              rot_tick = 1'b0;
    logic [ZONE_W-1:0] active_zone = '0;
    logic [CONC_W-1:0] conc_limit;
    logic              off_time_x2;
    logic              bal_global_off;
    logic              zone_skip_req;
    logic [ZONE_W-1:0] zone_skip_id;

    thermal_degrade_ctrl #(
        .TEMP_W(TEMP_W), .TIMEOUT_CYC(TMO), .NUM_ZONES(4), .SKIP_ROT(SKIPN)
    ) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    string tag = "R1";

    // Reference model: 0 normal, 1 degraded, 2 shutdown.
    int m_lvl = 2;
    int m_idle = 0;
    int m_skip = 0;
    int m_zone = 0;

    function automatic int rec(int thr, int h);
        return (thr > h) ? thr - h : 0;
    endfunction

    task automatic model_edge();
        int nl;
        int t;
        int r1;
        nl = m_lvl;
        t = int'(temp_code);
        r1 = rec(int'(thr_lo), int'(hyst_margin));
        if (temp_vld) begin
            m_idle = 0;
            if (t > int'(thr_hi)) nl = 2;
            else if (m_lvl == 0) nl = (t > int'(thr_lo)) ? 1 : 0;
            else if (m_lvl == 1) nl = (t < r1) ? 0 : 1;
            else if (t < rec(int'(thr_hi), int'(hyst_margin))) nl = (t < r1) ? 0 : 1;
            else nl = 2;
        end else begin
            m_idle++;
            if (m_idle >= TMO) nl = 2;
        end
        if (nl != 0) m_skip = 0;
        else if (temp_vld && m_lvl == 0 && t >= r1 && t <= int'(thr_lo) && m_skip == 0) begin
            m_skip = SKIPN;
            m_zone = int'(active_zone);
        end else if (rot_tick && m_skip > 0) m_skip--;
        m_lvl = nl;
    endtask

    task automatic check_all();
        int ec;
        int cfg;
        cfg = int'(cfg_conc);
        ec = (m_lvl == 2) ? 0 : (m_lvl == 1) ? 1 : ((cfg > 2) ? 2 : cfg);
        n_run++;
        if (int'(conc_limit) != ec || off_time_x2 != (m_lvl != 0) ||
            bal_global_off != (m_lvl == 2) || zone_skip_req != (m_skip > 0) ||
            (m_skip > 0 && int'(zone_skip_id) != m_zone)) begin
            n_fail++;
            $display("FAIL %s: conc=%0d x2=%0b off=%0b skip=%0b id=%0d expected conc=%0d x2=%0b off=%0b skip=%0b id=%0d",
                     tag, conc_limit, off_time_x2, bal_global_off, zone_skip_req, zone_skip_id,
                     ec, m_lvl != 0, m_lvl == 2, m_skip > 0, m_zone);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check_all();
        temp_vld = 1'b0;
        rot_tick = 1'b0;
    endtask

    task automatic sample(int t);
        temp_vld = 1'b1;
        temp_code = TEMP_W'(t);
        step();
    endtask

    task automatic tick();
        rot_tick = 1'b1;
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all();          // R1 reset state
        rst_n = 1'b1;
        tag = "R7"; step(); step();
        tag = "R6"; sample(50);          // shutdown straight to normal
        tag = "R4"; cfg_conc = 2'd1; step(); cfg_conc = 2'd3; step(); cfg_conc = 2'd2; step();
        tag = "R3"; sample(120);
        tag = "R5"; sample(95); sample(90); sample(89);
        tag = "R9"; active_zone = 2'd3; rot_tick = 1'b1; sample(95);  // tick in arm cycle
        tag = "R10"; active_zone = 2'd1; sample(92); tick(); step(); tick(); step();
        tag = "R2"; sample(160);
        tag = "R6"; sample(145); sample(140); sample(139); sample(160); sample(60);
        tag = "R11"; active_zone = 2'd2; sample(98); sample(101); step();
        tag = "R8"; sample(50);
        for (int i = 0; i < int'(TMO) - 1; i++) step();
        sample(40);           // valid in expiry cycle wins
        for (int i = 0; i < int'(TMO) + 2; i++) step();
        tag = "R6"; sample(120);
        tag = "R5"; hyst_margin = TEMP_W'(200); sample(0); sample(5);
        hyst_margin = TEMP_W'(10);
        tag = "R2"; sample(151);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule